// File: doc/BRIEF.md
# Dependence-Steered L1 Load Way Access Controller

This block drives the tag and data array enables for the load path of a four-way set-associative level-one data cache in an in-order pipeline. Each load arrives together with the register fields of the instruction right behind it. If that next instruction reads the register the load writes, the load must return in the shortest time. The controller then reads the tags and every data way in the same cycle and returns the data one cycle later. If the next instruction does not read that register, a spare cycle is free. The controller then reads the tags alone, and in the following cycle it enables only the way that matched. This saves the energy of the data ways that would otherwise be read for nothing.

A sequential hit holds the load port for one extra cycle through `req_ready`. A sequential miss is reported one cycle after the request, and no data way is touched. Three counters record how many data ways were activated and how many loads were served in each mode. The tag and data arrays are held in registers inside the block. They are written through a simple fill port that stands in for the refill path.

Top module: `load_way_ctrl`

## Requirements
- R1: A load is fast (parallel) exactly when `nxt_valid` is 1, `req_dst` is not register 0, and `req_dst` equals `nxt_src_a` or `nxt_src_b`; every other load is sequential.
- R2: In the cycle a fast load is accepted, `tag_rd_en` is 1 and all four bits of `data_way_en` are 1.
- R3: One cycle after a fast load, `rsp_done` and `rsp_fast` are 1 and `rsp_hit` shows the lookup result; on a hit `rsp_valid` is 1, `rsp_way` holds the way number and `rsp_data` holds the stored word.
- R4: In the cycle a sequential load is accepted, `tag_rd_en` is 1 and `data_way_en` is 0. On a hit, the next cycle has exactly one enable bit set, bit w for way w.
- R5: A sequential hit returns `rsp_done`, `rsp_valid`, `rsp_hit`, `rsp_way` and `rsp_data` two cycles after the request, with `rsp_fast` 0; `req_ready` is 0 in the cycle between.
- R6: A sequential miss enables no data way, gives `rsp_done`=1, `rsp_hit`=0 and `rsp_valid`=0 one cycle after the request, and keeps `req_ready` at 1.
- R7: A fast miss still enables all four ways, then gives `rsp_done`=1, `rsp_hit`=0 and `rsp_valid`=0 one cycle later.
- R8: `cnt_way_en` adds the number of set `data_way_en` bits each cycle, and `cnt_fast` and `cnt_seq` count the loads accepted in each mode. All three are 0 after reset.
- R9: The set index is `addr[IDX_W-1:0]` and the tag is the bits above it. A fill writes the tag, valid bit and word of one way, and a later load to that address hits that way. Reset clears every valid bit.
- R10: While reset is held and just after it, `req_ready` is 1 and `tag_rd_en`, `data_way_en`, `rsp_done` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Load word address |
| req_dst | input | 5 | Destination register of the load |
| nxt_valid | input | 1 | Next instruction present |
| nxt_src_a | input | 5 | First source register of the next instruction |
| nxt_src_b | input | 5 | Second source register of the next instruction |
| req_ready | output | 1 | Load port can accept a request |
| fill_en | input | 1 | Write one line into the arrays |
| fill_way | input | WAY_W | Way written by the fill |
| fill_addr | input | ADDR_W | Address (tag and set) written by the fill |
| fill_data | input | DATA_W | Word written by the fill |
| tag_rd_en | output | 1 | Tag array read enable |
| data_way_en | output | WAYS | Per-way data array read enables |
| rsp_done | output | 1 | Lookup finished (hit or miss) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_valid | output | 1 | Load data valid strobe |
| rsp_way | output | WAY_W | Way that hit |
| rsp_fast | output | 1 | Response came from a fast load |
| rsp_data | output | DATA_W | Load data, zero unless rsp_valid |
| cnt_way_en | output | CNT_W | Data way activations |
| cnt_fast | output | CNT_W | Fast loads served |
| cnt_seq | output | CNT_W | Sequential loads served |

## Verification
A wrong mode decision shows in the request cycle itself, as four enable bits where none were expected or the reverse. It shows again one cycle later as `rsp_fast` and response timing that do not fit. A corrupt second-stage register shows in the very next cycle: `req_ready` stays low, or the single enable bit sits on the wrong way. The wrong word then follows a cycle after that. Counter drift is invisible per load, so the bench compares all three counters against its own totals after each scenario.

// File: rtl/lwc_pkg.sv
package lwc_pkg;

    localparam int LWC_REG_W  = 5;
    localparam int LWC_WAYS   = 4;
    localparam int LWC_ADDR_W = 12;
    localparam int LWC_IDX_W  = 4;
    localparam int LWC_DATA_W = 32;
    localparam int LWC_CNT_W  = 16;

    typedef logic [LWC_REG_W-1:0] reg_id_t;

    typedef enum logic {
        ACC_SEQ  = 1'b0,
        ACC_FAST = 1'b1
    } access_mode_e;

    typedef struct packed {
        logic    valid;
        reg_id_t src_a;
        reg_id_t src_b;
    } next_instr_t;

    // True when the following instruction consumes the load result.
    function automatic logic consumes_result(input reg_id_t dst, input next_instr_t nxt);
        return nxt.valid && (dst != '0) && ((nxt.src_a == dst) || (nxt.src_b == dst));
    endfunction

endpackage

// File: rtl/lwc_dep_check.sv
module lwc_dep_check
    import lwc_pkg::*;
(
    input  logic         nxt_valid,
    input  reg_id_t      dst,
    input  reg_id_t      src_a,
    input  reg_id_t      src_b,
    output access_mode_e mode
);
    next_instr_t nxt;

    always_comb begin
        nxt.valid = nxt_valid;
        nxt.src_a = src_a;
        nxt.src_b = src_b;
        mode      = consumes_result(dst, nxt) ? ACC_FAST : ACC_SEQ;
    end

endmodule

// File: rtl/lwc_tag_array.sv
module lwc_tag_array #(
    parameter int WAYS   = 4,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SETS  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way
);
    logic [TAG_W-1:0] tags  [WAYS][SETS];
    logic [SETS-1:0]  valid [WAYS];
    logic [WAYS-1:0]  match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_ff @(posedge clk) begin
            if (rst) begin
                valid[w] <= '0;
            end else if (fill_en && (fill_way == WAY_W'(w))) begin
                valid[w][fill_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == WAY_W'(w))) begin
                tags[w][fill_idx] <= fill_tag;
            end
        end

        assign match[w] = valid[w][lk_idx] && (tags[w][lk_idx] == lk_tag);
    end

    always_comb begin
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) lk_way = WAY_W'(w);
        end
    end

    assign lk_hit = |match;

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R9

endmodule

// File: rtl/lwc_data_array.sv
module lwc_data_array #(
    parameter int WAYS   = 4,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SETS  = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              fill_en,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [WAYS-1:0]   rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WAY_W-1:0]  sel_way,
    output logic [DATA_W-1:0] sel_data
);
    logic [DATA_W-1:0] mem  [WAYS][SETS];
    logic [DATA_W-1:0] dout [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == WAY_W'(w))) begin
                mem[w][fill_idx] <= fill_data;
            end
            if (rd_en[w]) begin
                dout[w] <= mem[w][rd_idx];
            end
        end
    end

    assign sel_data = dout[sel_way];

endmodule

// File: rtl/lwc_act_counter.sv
module lwc_act_counter #(
    parameter int WAYS  = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WAYS-1:0]  way_en,
    input  logic             acc_fast,
    input  logic             acc_seq,
    output logic [CNT_W-1:0] cnt_way,
    output logic [CNT_W-1:0] cnt_fast,
    output logic [CNT_W-1:0] cnt_seq
);
    logic [CNT_W-1:0] n_en;

    always_comb begin
        n_en = '0;
        for (int w = 0; w < WAYS; w++) begin
            n_en = n_en + CNT_W'(way_en[w]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_way  <= '0;
            cnt_fast <= '0;
            cnt_seq  <= '0;
        end else begin
            cnt_way  <= cnt_way + n_en;
            cnt_fast <= cnt_fast + CNT_W'(acc_fast);
            cnt_seq  <= cnt_seq + CNT_W'(acc_seq);
        end
    end

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (way_en == '0) |=> $stable(cnt_way)); // R8

    AST_CNT_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(acc_fast && acc_seq)); // R8

endmodule

// File: rtl/load_way_ctrl.sv
module load_way_ctrl
    import lwc_pkg::*;
#(
    parameter int WAYS   = LWC_WAYS,
    parameter int ADDR_W = LWC_ADDR_W,
    parameter int IDX_W  = LWC_IDX_W,
    parameter int DATA_W = LWC_DATA_W,
    parameter int CNT_W  = LWC_CNT_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LWC_REG_W-1:0] req_dst,
    input  logic              nxt_valid,
    input  logic [LWC_REG_W-1:0] nxt_src_a,
    input  logic [LWC_REG_W-1:0] nxt_src_b,
    output logic              req_ready,
    input  logic              fill_en,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              tag_rd_en,
    output logic [WAYS-1:0]   data_way_en,
    output logic              rsp_done,
    output logic              rsp_hit,
    output logic              rsp_valid,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_fast,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  cnt_way_en,
    output logic [CNT_W-1:0]  cnt_fast,
    output logic [CNT_W-1:0]  cnt_seq
);
    typedef struct packed {
        logic             valid;
        access_mode_e     mode;
        logic             hit;
        logic [WAY_W-1:0] way;
        logic [IDX_W-1:0] idx;
    } stage_t;

    access_mode_e     req_mode;
    logic             fast;
    logic             accept;
    logic             seq_busy;
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    logic [IDX_W-1:0] req_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [DATA_W-1:0] sel_data;
    stage_t           s1_q;

    assign req_idx = req_addr[IDX_W-1:0];

    lwc_dep_check u_dep (
        .nxt_valid (nxt_valid),
        .dst       (req_dst),
        .src_a     (nxt_src_a),
        .src_b     (nxt_src_b),
        .mode      (req_mode)
    );

    assign fast      = (req_mode == ACC_FAST);
    assign seq_busy  = s1_q.valid && (s1_q.mode == ACC_SEQ) && s1_q.hit;
    assign req_ready = !seq_busy;
    assign accept    = req_valid && !seq_busy && !rst;
    assign tag_rd_en = accept;

    lwc_tag_array #(.WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_en),
        .fill_way (fill_way),
        .fill_idx (fill_addr[IDX_W-1:0]),
        .fill_tag (fill_addr[ADDR_W-1:IDX_W]),
        .lk_idx   (req_idx),
        .lk_tag   (req_addr[ADDR_W-1:IDX_W]),
        .lk_hit   (lk_hit),
        .lk_way   (lk_way)
    );

    // Way enables: all ways for a fast load, the matched way one cycle later
    // for a sequential hit, nothing otherwise.
    always_comb begin
        data_way_en = '0;
        rd_idx      = req_idx;
        if (seq_busy) begin
            data_way_en[s1_q.way] = 1'b1;
            rd_idx                = s1_q.idx;
        end else if (accept && fast) begin
            data_way_en = '1;
        end
    end

    lwc_data_array #(.WAYS(WAYS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .fill_en   (fill_en),
        .fill_way  (fill_way),
        .fill_idx  (fill_addr[IDX_W-1:0]),
        .fill_data (fill_data),
        .rd_en     (data_way_en),
        .rd_idx    (rd_idx),
        .sel_way   (rsp_way),
        .sel_data  (sel_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '0;
            rsp_done  <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_way   <= '0;
            rsp_fast  <= 1'b0;
        end else begin
            s1_q.valid <= accept;
            s1_q.mode  <= req_mode;
            s1_q.hit   <= lk_hit;
            s1_q.way   <= lk_way;
            s1_q.idx   <= req_idx;
            rsp_fast   <= accept && fast;
            if (seq_busy) begin
                rsp_done  <= 1'b1;
                rsp_hit   <= 1'b1;
                rsp_valid <= 1'b1;
                rsp_way   <= s1_q.way;
            end else if (accept) begin
                rsp_done  <= fast || !lk_hit;
                rsp_hit   <= lk_hit;
                rsp_valid <= fast && lk_hit;
                rsp_way   <= lk_way;
            end else begin
                rsp_done  <= 1'b0;
                rsp_hit   <= 1'b0;
                rsp_valid <= 1'b0;
            end
        end
    end

    assign rsp_data = rsp_valid ? sel_data : '0;

    lwc_act_counter #(.WAYS(WAYS), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .way_en   (data_way_en),
        .acc_fast (accept && fast),
        .acc_seq  (accept && !fast),
        .cnt_way  (cnt_way_en),
        .cnt_fast (cnt_fast),
        .cnt_seq  (cnt_seq)
    );

    AST_FAST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (accept && fast) |=> (rsp_done && rsp_fast)); // R3

    AST_VALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit && rsp_done)); // R3

    AST_SEQ_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
        (accept && !fast && lk_hit) |=> ($onehot(data_way_en) && !req_ready)); // R4

    AST_SEQ_HIT_DATA: assert property (@(posedge clk) disable iff (rst)
        (accept && !fast && lk_hit) |-> ##2 (rsp_valid && !rsp_fast)); // R5

    AST_SEQ_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (accept && !fast && !lk_hit) |=> (rsp_done && !rsp_valid && (data_way_en == '0) && req_ready)); // R6

endmodule

// File: tb/load_way_ctrl_test.sv
module load_way_ctrl_test;
    localparam int WAYS   = 4;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int WAY_W  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [4:0]        req_dst = '0;
    logic              nxt_valid = 1'b0;
    logic [4:0]        nxt_src_a = '0;
    logic [4:0]        nxt_src_b = '0;
    logic              req_ready;
    logic              fill_en = 1'b0;
    logic [WAY_W-1:0]  fill_way = '0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              tag_rd_en;
    logic [WAYS-1:0]   data_way_en;
    logic              rsp_done, rsp_hit, rsp_valid, rsp_fast;
    logic [WAY_W-1:0]  rsp_way;
    logic [DATA_W-1:0] rsp_data;
    logic [CNT_W-1:0]  cnt_way_en, cnt_fast, cnt_seq;

    int n_chk = 0;
    int n_bad = 0;
    int m_ways = 0;
    int m_fast = 0;
    int m_seq = 0;

    always #10 clk = ~clk;

    load_way_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_dst(req_dst), .nxt_valid(nxt_valid), .nxt_src_a(nxt_src_a),
        .nxt_src_b(nxt_src_b), .req_ready(req_ready), .fill_en(fill_en),
        .fill_way(fill_way), .fill_addr(fill_addr), .fill_data(fill_data),
        .tag_rd_en(tag_rd_en), .data_way_en(data_way_en), .rsp_done(rsp_done),
        .rsp_hit(rsp_hit), .rsp_valid(rsp_valid), .rsp_way(rsp_way),
        .rsp_fast(rsp_fast), .rsp_data(rsp_data), .cnt_way_en(cnt_way_en),
        .cnt_fast(cnt_fast), .cnt_seq(cnt_seq)
    );

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] tag_of(input int set, input int way);
        return 8'(16 * (way + 1) + set);
    endfunction

    function automatic logic [ADDR_W-1:0] addr_of(input int set, input int way);
        return {tag_of(set, way), 4'(set)};
    endfunction

    function automatic logic [DATA_W-1:0] word_of(input int set, input int way);
        return 32'((way + 1) << 28) | 32'(set << 8) | 32'h42;
    endfunction

    task automatic fill(input int set, input int way);
        @(negedge clk);
        fill_en   = 1'b1;
        fill_way  = WAY_W'(way);
        fill_addr = addr_of(set, way);
        fill_data = word_of(set, way);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // One load; expected mode comes from the bench's own dependence rule (R1).
    task automatic do_load(input string rq, input logic [ADDR_W-1:0] addr, input logic [4:0] dst,
                           input logic nv, input logic [4:0] a, input logic [4:0] b,
                           input logic exp_hit, input int exp_way, input logic [DATA_W-1:0] exp_dat);
        logic exp_fast;
        exp_fast = nv && (dst != 5'd0) && ((a == dst) || (b == dst));
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_dst = dst;
        nxt_valid = nv; nxt_src_a = a; nxt_src_b = b;
        #1;
        chk(rq, "tag_rd_en req cycle", 64'(tag_rd_en), 64'd1);
        chk(exp_fast ? "R2" : "R4", "data_way_en req cycle", 64'(data_way_en), exp_fast ? 64'hF : 64'h0);
        @(negedge clk);
        req_valid = 1'b0; nxt_valid = 1'b0;
        #1;
        if (exp_fast) begin
            m_fast++; m_ways += 4;
            chk(rq, "rsp_done fast", 64'(rsp_done), 64'd1);
            chk("R3", "rsp_fast", 64'(rsp_fast), 64'd1);
            chk(exp_hit ? "R3" : "R7", "rsp_hit fast", 64'(rsp_hit), 64'(exp_hit));
            chk(exp_hit ? "R3" : "R7", "rsp_valid fast", 64'(rsp_valid), 64'(exp_hit));
            if (exp_hit) begin
                chk("R3", "rsp_way fast", 64'(rsp_way), 64'(exp_way));
                chk("R3", "rsp_data fast", 64'(rsp_data), 64'(exp_dat));
            end
            chk(rq, "data_way_en after fast", 64'(data_way_en), 64'h0);
        end else if (exp_hit) begin
            m_seq++; m_ways += 1;
            chk("R4", "single way enable", 64'(data_way_en), 64'(1 << exp_way));
            chk("R5", "req_ready stall", 64'(req_ready), 64'd0);
            chk("R5", "no early rsp_done", 64'(rsp_done), 64'd0);
            @(negedge clk);
            #1;
            chk("R5", "rsp_done seq", 64'(rsp_done), 64'd1);
            chk("R5", "rsp_valid seq", 64'(rsp_valid), 64'd1);
            chk("R5", "rsp_hit seq", 64'(rsp_hit), 64'd1);
            chk("R5", "rsp_fast seq", 64'(rsp_fast), 64'd0);
            chk("R5", "rsp_way seq", 64'(rsp_way), 64'(exp_way));
            chk("R5", "rsp_data seq", 64'(rsp_data), 64'(exp_dat));
            chk("R5", "ready back", 64'(req_ready), 64'd1);
            chk("R4", "data_way_en after seq", 64'(data_way_en), 64'h0);
        end else begin
            m_seq++;
            chk("R6", "rsp_done seq miss", 64'(rsp_done), 64'd1);
            chk("R6", "rsp_hit seq miss", 64'(rsp_hit), 64'd0);
            chk("R6", "rsp_valid seq miss", 64'(rsp_valid), 64'd0);
            chk("R6", "no way enable", 64'(data_way_en), 64'h0);
            chk("R6", "ready seq miss", 64'(req_ready), 64'd1);
        end
    endtask

    task automatic check_counters(input string what);
        chk("R8", {what, " cnt_way_en"}, 64'(cnt_way_en), 64'(m_ways));
        chk("R8", {what, " cnt_fast"}, 64'(cnt_fast), 64'(m_fast));
        chk("R8", {what, " cnt_seq"}, 64'(cnt_seq), 64'(m_seq));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "ready in reset", 64'(req_ready), 64'd1);
        chk("R10", "tag_rd_en in reset", 64'(tag_rd_en), 64'd0);
        chk("R10", "data_way_en in reset", 64'(data_way_en), 64'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10", "rsp_done after reset", 64'(rsp_done), 64'd0);
        chk("R10", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check_counters("after reset");
    endtask

    task automatic t_cold_miss;
        // R9: nothing valid after reset, so every way misses.
        do_load("R7", addr_of(3, 0), 5'd4, 1'b1, 5'd4, 5'd0, 1'b0, 0, '0);
        do_load("R6", addr_of(3, 1), 5'd4, 1'b1, 5'd7, 5'd8, 1'b0, 0, '0);
        check_counters("cold");
    endtask

    task automatic t_fill_hits;
        for (int w = 0; w < WAYS; w++) fill(3, w);
        fill(9, 2);
        for (int w = 0; w < WAYS; w++)
            do_load("R9", addr_of(3, w), 5'd6, 1'b1, 5'd1, 5'd6, 1'b1, w, word_of(3, w));
        do_load("R9", addr_of(9, 2), 5'd6, 1'b1, 5'd6, 5'd1, 1'b1, 2, word_of(9, 2));
        check_counters("fast hits");
    endtask

    task automatic t_seq_hits;
        for (int w = WAYS - 1; w >= 0; w--)
            do_load("R4", addr_of(3, w), 5'd9, 1'b1, 5'd2, 5'd3, 1'b1, w, word_of(3, w));
        check_counters("seq hits");
    endtask

    task automatic t_dependence;
        // R1: register 0 never makes a dependence, nor does an absent next instruction.
        do_load("R1", addr_of(3, 1), 5'd0, 1'b1, 5'd0, 5'd0, 1'b1, 1, word_of(3, 1));
        do_load("R1", addr_of(3, 2), 5'd12, 1'b0, 5'd12, 5'd12, 1'b1, 2, word_of(3, 2));
        do_load("R1", addr_of(3, 0), 5'd12, 1'b1, 5'd12, 5'd3, 1'b1, 0, word_of(3, 0));
        do_load("R1", addr_of(3, 3), 5'd31, 1'b1, 5'd30, 5'd31, 1'b1, 3, word_of(3, 3));
        check_counters("dependence");
    endtask

    task automatic t_misses;
        do_load("R6", addr_of(9, 1), 5'd5, 1'b0, 5'd0, 5'd0, 1'b0, 0, '0);
        do_load("R7", addr_of(9, 3), 5'd5, 1'b1, 5'd5, 5'd0, 1'b0, 0, '0);
        check_counters("misses");
    endtask

    initial begin
        #(20 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_cold_miss();
        t_fill_hits();
        t_seq_hits();
        t_dependence();
        t_misses();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule